// File: doc/BRIEF.md
# AC97 Host Register and DMA Engine

This block is the host-side register file and DMA engine of an AC97 audio controller. Software reaches it through a 32-bit word register bus. A set of codec command registers holds the address and data of a codec register access. Writing the command control word with its request bit set fires a single-cycle interrupt toward the link logic. The value of the direction bit chooses whether that is the request interrupt or the reply interrupt.

Two DMA channels carry audio frames. A frame is one stereo pair of signed 16-bit samples at 48 kHz, so it is 4 bytes wide. The downstream (playback) channel reads memory one frame per beat and offers each frame on a ready/valid stream toward the codec link. The upstream (capture) channel accepts frames from the link and writes them to memory with byte strobes. Each channel has an address register and a remaining-byte count. Each channel fires its own done pulse when an enabled transfer takes the count to zero. Serial framing and the codec itself sit outside this block.

Top module: `ac97_host_dma`

## Requirements
- R1: Registers sit at byte address 4*index, with these indices: 0 command control, 1 command address, 2 command data out, 3 command data in, 4 downstream control, 5 downstream address, 6 downstream remaining, 8 upstream control, 9 upstream address, 10 upstream remaining. Each one reads back what was last written, except where another requirement says otherwise.
- R2: In command control, bit 0 (request) is never stored and always reads back as 0. All other bits are stored as written.
- R3: A write to command control with bit 0 set produces a one-cycle pulse in the cycle after the write. The pulse is on cmdReqIrq when bit 1 is 1 and on cmdRplIrq when bit 1 is 0. A write with bit 0 clear pulses neither.
- R4: Bit 0 of each DMA control register enables that channel. A disabled channel issues no memory access, holds capReady low, and leaves its address and count unchanged.
- R5: Each beat moves min(remaining, 4) bytes. After the beat, the address has grown by that amount and the count has shrunk by it. Playback reads memory at the channel address and presents the returned word on pbData, with pbKeep marking the valid low bytes. Capture writes capData to the channel address, with memWrStrb marking the valid low bytes.
- R6: The beat that takes an enabled channel's count to zero raises exactly one one-cycle pulse. The pulse is on dnDoneIrq for playback and on upDoneIrq for capture.
- R7: No beat and no done pulse occur while the count is zero. None occur while a playback frame waits on pbReady, or while capValid is low. A held playback frame keeps pbValid and pbData stable.
- R8: An access whose byte enables are not all 1, or whose address is not word aligned, is ignored. Such a write changes nothing and such a read returns 0.
- R9: Index 7 and all indices of 11 and above read 0, and writes to them have no effect.
- R10: Reset clears every register and leaves all memory, stream and interrupt outputs inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | ADDR_W | Register byte address |
| regByteEn | input | 4 | Byte enables; only all-ones accesses are accepted |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data (combinational from regAddr) |
| memRdEn | output | 1 | Playback memory read request |
| memRdAddr | output | 32 | Playback memory read byte address |
| memRdData | input | FRAME_W | Read data, valid one cycle after memRdEn |
| memWrEn | output | 1 | Capture memory write strobe |
| memWrAddr | output | 32 | Capture memory write byte address |
| memWrData | output | FRAME_W | Capture memory write data |
| memWrStrb | output | FRAME_W/8 | Capture write byte strobes |
| pbValid | output | 1 | Playback frame valid |
| pbData | output | FRAME_W | Playback frame |
| pbKeep | output | FRAME_W/8 | Valid bytes of the playback frame |
| pbReady | input | 1 | Link accepts the playback frame |
| capValid | input | 1 | Capture frame valid |
| capData | input | FRAME_W | Capture frame |
| capReady | output | 1 | Block accepts the capture frame |
| cmdReqIrq | output | 1 | Command request pulse |
| cmdRplIrq | output | 1 | Command reply pulse |
| dnDoneIrq | output | 1 | Playback done pulse |
| upDoneIrq | output | 1 | Capture done pulse |

## Verification
The embedded properties check several things on every cycle. The two command pulses never coincide, and each traces back to an accepted full-width write. A done pulse appears only with its count at zero and straight after a beat. A count never steps below zero, and each step subtracts exactly the beat size. A stalled playback frame holds steady. The directed scenarios have to show the rest: the exact address sequence and byte masks of odd-length buffers, the total number of beats and pulses per buffer, and that disabled channels, reserved slots and partial accesses leave every register intact.

// File: rtl/ac97_host_pkg.sv
package ac97_host_pkg;
  localparam int unsigned IDX_CMD_CTRL = 0;
  localparam int unsigned IDX_CMD_ADDR = 1;
  localparam int unsigned IDX_CMD_DOUT = 2;
  localparam int unsigned IDX_CMD_DIN  = 3;
  localparam int unsigned IDX_DN_CTRL  = 4;
  localparam int unsigned IDX_DN_ADDR  = 5;
  localparam int unsigned IDX_DN_REM   = 6;
  localparam int unsigned IDX_UP_CTRL  = 8;
  localparam int unsigned IDX_UP_ADDR  = 9;
  localparam int unsigned IDX_UP_REM   = 10;

  // Strobes from register control to the DMA datapath
  typedef struct packed {
    logic ldDnAddr;
    logic ldDnRem;
    logic ldUpAddr;
    logic ldUpRem;
    logic dnEn;
    logic upEn;
  } dmaStrobe_t;
endpackage

// File: rtl/ac97_dma_counter.sv
module ac97_dma_counter #(
  parameter int REG_W       = 32,
  parameter int FRAME_BYTES = 4,
  localparam int BEAT_W     = $clog2(FRAME_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ldAddr,
  input  logic              ldRem,
  input  logic [REG_W-1:0]  wrData,
  input  logic              advance,
  output logic [REG_W-1:0]  addr,
  output logic [REG_W-1:0]  rem,
  output logic [BEAT_W-1:0] beatBytes,
  output logic              lastBeat
);
  always_comb begin
    if (rem < REG_W'(FRAME_BYTES)) beatBytes = rem[BEAT_W-1:0];
    else                           beatBytes = BEAT_W'(FRAME_BYTES);
    lastBeat = (rem != '0) && (rem <= REG_W'(FRAME_BYTES));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addr <= '0;
      rem  <= '0;
    end else begin
      if (ldAddr)       addr <= wrData;
      else if (advance) addr <= addr + REG_W'(beatBytes);
      if (ldRem)        rem  <= wrData;
      else if (advance) rem  <= rem - REG_W'(beatBytes);
    end
  end

  // R7: a beat is never taken from an empty count
  a_r7_no_wrap: assert property (@(posedge clk) disable iff (!rstN)
    advance |-> rem != '0);
  // R5: count shrinks by exactly the beat size
  a_r5_rem_step: assert property (@(posedge clk) disable iff (!rstN)
    (advance && !ldRem) |=> rem == $past(rem) - REG_W'($past(beatBytes)));
endmodule

// File: rtl/ac97_host_ctrl.sv
module ac97_host_ctrl
  import ac97_host_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int REG_W  = 32,
  localparam int IDX_W = ADDR_W - 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [3:0]        regByteEn,
  input  logic [REG_W-1:0]  regWrData,
  output logic [REG_W-1:0]  regRdData,
  input  logic [REG_W-1:0]  dnAddr,
  input  logic [REG_W-1:0]  dnRem,
  input  logic [REG_W-1:0]  upAddr,
  input  logic [REG_W-1:0]  upRem,
  output dmaStrobe_t        strobe,
  output logic              cmdReqIrq,
  output logic              cmdRplIrq
);
  logic [IDX_W-1:0] wordIdx;
  logic fullAccess;
  logic hitCmdCtrl, hitCmdAddr, hitCmdDout, hitCmdDin;
  logic hitDnCtrl, hitDnAddr, hitDnRem, hitUpCtrl, hitUpAddr, hitUpRem;
  logic [REG_W-1:0] cmdCtrl, cmdAddr, cmdDout, cmdDin, dnCtrl, upCtrl;

  assign wordIdx    = regAddr[ADDR_W-1:2];
  assign fullAccess = (&regByteEn) && (regAddr[1:0] == 2'b00);

  always_comb begin
    hitCmdCtrl = fullAccess && (wordIdx == IDX_W'(IDX_CMD_CTRL));
    hitCmdAddr = fullAccess && (wordIdx == IDX_W'(IDX_CMD_ADDR));
    hitCmdDout = fullAccess && (wordIdx == IDX_W'(IDX_CMD_DOUT));
    hitCmdDin  = fullAccess && (wordIdx == IDX_W'(IDX_CMD_DIN));
    hitDnCtrl  = fullAccess && (wordIdx == IDX_W'(IDX_DN_CTRL));
    hitDnAddr  = fullAccess && (wordIdx == IDX_W'(IDX_DN_ADDR));
    hitDnRem   = fullAccess && (wordIdx == IDX_W'(IDX_DN_REM));
    hitUpCtrl  = fullAccess && (wordIdx == IDX_W'(IDX_UP_CTRL));
    hitUpAddr  = fullAccess && (wordIdx == IDX_W'(IDX_UP_ADDR));
    hitUpRem   = fullAccess && (wordIdx == IDX_W'(IDX_UP_REM));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdCtrl   <= '0;
      cmdAddr   <= '0;
      cmdDout   <= '0;
      cmdDin    <= '0;
      dnCtrl    <= '0;
      upCtrl    <= '0;
      cmdReqIrq <= 1'b0;
      cmdRplIrq <= 1'b0;
    end else begin
      cmdReqIrq <= regWrEn && hitCmdCtrl && regWrData[0] && regWrData[1];
      cmdRplIrq <= regWrEn && hitCmdCtrl && regWrData[0] && !regWrData[1];
      if (regWrEn) begin
        if (hitCmdCtrl) cmdCtrl <= {regWrData[REG_W-1:1], 1'b0};
        if (hitCmdAddr) cmdAddr <= regWrData;
        if (hitCmdDout) cmdDout <= regWrData;
        if (hitCmdDin)  cmdDin  <= regWrData;
        if (hitDnCtrl)  dnCtrl  <= regWrData;
        if (hitUpCtrl)  upCtrl  <= regWrData;
      end
    end
  end

  always_comb begin
    regRdData = '0;
    if (hitCmdCtrl) regRdData = cmdCtrl;
    if (hitCmdAddr) regRdData = cmdAddr;
    if (hitCmdDout) regRdData = cmdDout;
    if (hitCmdDin)  regRdData = cmdDin;
    if (hitDnCtrl)  regRdData = dnCtrl;
    if (hitDnAddr)  regRdData = dnAddr;
    if (hitDnRem)   regRdData = dnRem;
    if (hitUpCtrl)  regRdData = upCtrl;
    if (hitUpAddr)  regRdData = upAddr;
    if (hitUpRem)   regRdData = upRem;
  end

  always_comb begin
    strobe.ldDnAddr = regWrEn && hitDnAddr;
    strobe.ldDnRem  = regWrEn && hitDnRem;
    strobe.ldUpAddr = regWrEn && hitUpAddr;
    strobe.ldUpRem  = regWrEn && hitUpRem;
    strobe.dnEn     = dnCtrl[0];
    strobe.upEn     = upCtrl[0];
  end

  // R3: the two command pulses are mutually exclusive
  a_r3_one_kind: assert property (@(posedge clk) disable iff (!rstN)
    !(cmdReqIrq && cmdRplIrq));
  // R3: a request pulse follows a write carrying request and write bits
  a_r3_req_from_write: assert property (@(posedge clk) disable iff (!rstN)
    cmdReqIrq |-> $past(regWrEn && regWrData[0] && regWrData[1]));
  // R8: no command pulse after a partial-width access
  a_r8_full_width: assert property (@(posedge clk) disable iff (!rstN)
    (cmdReqIrq || cmdRplIrq) |-> $past(&regByteEn));
endmodule

// File: rtl/ac97_host_datapath.sv
module ac97_host_datapath
  import ac97_host_pkg::*;
#(
  parameter int REG_W        = 32,
  parameter int FRAME_W      = 32,
  localparam int FRAME_BYTES = FRAME_W / 8,
  localparam int BEAT_W      = $clog2(FRAME_BYTES + 1)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  dmaStrobe_t             strobe,
  input  logic [REG_W-1:0]       wrData,
  output logic [REG_W-1:0]       dnAddr,
  output logic [REG_W-1:0]       dnRem,
  output logic [REG_W-1:0]       upAddr,
  output logic [REG_W-1:0]       upRem,
  output logic                   memRdEn,
  output logic [REG_W-1:0]       memRdAddr,
  input  logic [FRAME_W-1:0]     memRdData,
  output logic                   memWrEn,
  output logic [REG_W-1:0]       memWrAddr,
  output logic [FRAME_W-1:0]     memWrData,
  output logic [FRAME_BYTES-1:0] memWrStrb,
  output logic                   pbValid,
  output logic [FRAME_W-1:0]     pbData,
  output logic [FRAME_BYTES-1:0] pbKeep,
  input  logic                   pbReady,
  input  logic                   capValid,
  input  logic [FRAME_W-1:0]     capData,
  output logic                   capReady,
  output logic                   dnDoneIrq,
  output logic                   upDoneIrq
);
  localparam int NUM_DIR = 2;  // 0 = playback, 1 = capture

  logic [REG_W-1:0]       chAddr [NUM_DIR];
  logic [REG_W-1:0]       chRem  [NUM_DIR];
  logic [BEAT_W-1:0]      chBeat [NUM_DIR];
  logic [FRAME_BYTES-1:0] chMask [NUM_DIR];
  logic [NUM_DIR-1:0]     chLast, chLdA, chLdR, chAdv, chEn;

  assign chLdA = {strobe.ldUpAddr, strobe.ldDnAddr};
  assign chLdR = {strobe.ldUpRem,  strobe.ldDnRem};
  assign chEn  = {strobe.upEn,     strobe.dnEn};

  for (genvar ch = 0; ch < NUM_DIR; ch++) begin : gCh
    ac97_dma_counter #(.REG_W(REG_W), .FRAME_BYTES(FRAME_BYTES)) cnt_i (
      .clk(clk), .rstN(rstN),
      .ldAddr(chLdA[ch]), .ldRem(chLdR[ch]), .wrData(wrData),
      .advance(chAdv[ch]),
      .addr(chAddr[ch]), .rem(chRem[ch]),
      .beatBytes(chBeat[ch]), .lastBeat(chLast[ch])
    );
    for (genvar b = 0; b < FRAME_BYTES; b++) begin : gMask
      assign chMask[ch][b] = (BEAT_W'(b) < chBeat[ch]);
    end
  end

  assign dnAddr = chAddr[0];
  assign dnRem  = chRem[0];
  assign upAddr = chAddr[1];
  assign upRem  = chRem[1];

  // Playback: one read outstanding, frame register toward the link
  logic dnIssue, dnInFlight;
  logic [FRAME_BYTES-1:0] dnKeepPend;

  assign dnIssue   = chEn[0] && (chRem[0] != '0) && !dnInFlight && !pbValid
                     && !(chLdA[0] || chLdR[0]);
  assign chAdv[0]  = dnIssue;
  assign memRdEn   = dnIssue;
  assign memRdAddr = chAddr[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dnInFlight <= 1'b0;
      dnKeepPend <= '0;
      pbValid    <= 1'b0;
      pbData     <= '0;
      pbKeep     <= '0;
      dnDoneIrq  <= 1'b0;
    end else begin
      dnInFlight <= dnIssue;
      dnDoneIrq  <= dnIssue && chLast[0];
      if (dnIssue) dnKeepPend <= chMask[0];
      if (dnInFlight) begin
        pbValid <= 1'b1;
        pbData  <= memRdData;
        pbKeep  <= dnKeepPend;
      end else if (pbReady) begin
        pbValid <= 1'b0;
      end
    end
  end

  // Capture: accept a frame whenever enabled with bytes left
  logic upTake;
  assign capReady = chEn[1] && (chRem[1] != '0) && !(chLdA[1] || chLdR[1]);
  assign upTake   = capValid && capReady;
  assign chAdv[1] = upTake;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memWrEn   <= 1'b0;
      memWrAddr <= '0;
      memWrData <= '0;
      memWrStrb <= '0;
      upDoneIrq <= 1'b0;
    end else begin
      memWrEn   <= upTake;
      upDoneIrq <= upTake && chLast[1];
      if (upTake) begin
        memWrAddr <= chAddr[1];
        memWrData <= capData;
        memWrStrb <= chMask[1];
      end
    end
  end

  // R6: playback done pulse only right after a read with the count now empty
  a_r6_dn_done: assert property (@(posedge clk) disable iff (!rstN)
    dnDoneIrq |-> (dnRem == '0) && $past(memRdEn));
  // R6: capture done pulse accompanies the final memory write
  a_r6_up_done: assert property (@(posedge clk) disable iff (!rstN)
    upDoneIrq |-> (upRem == '0) && memWrEn);
  // R7: a stalled playback frame stays put
  a_r7_pb_hold: assert property (@(posedge clk) disable iff (!rstN)
    (pbValid && !pbReady) |=> pbValid && $stable(pbData));
endmodule

// File: rtl/ac97_host_dma.sv
module ac97_host_dma
  import ac97_host_pkg::*;
#(
  parameter int ADDR_W       = 6,
  parameter int FRAME_W      = 32,
  localparam int REG_W       = 32,
  localparam int FRAME_BYTES = FRAME_W / 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   regWrEn,
  input  logic [ADDR_W-1:0]      regAddr,
  input  logic [3:0]             regByteEn,
  input  logic [REG_W-1:0]       regWrData,
  output logic [REG_W-1:0]       regRdData,
  output logic                   memRdEn,
  output logic [REG_W-1:0]       memRdAddr,
  input  logic [FRAME_W-1:0]     memRdData,
  output logic                   memWrEn,
  output logic [REG_W-1:0]       memWrAddr,
  output logic [FRAME_W-1:0]     memWrData,
  output logic [FRAME_BYTES-1:0] memWrStrb,
  output logic                   pbValid,
  output logic [FRAME_W-1:0]     pbData,
  output logic [FRAME_BYTES-1:0] pbKeep,
  input  logic                   pbReady,
  input  logic                   capValid,
  input  logic [FRAME_W-1:0]     capData,
  output logic                   capReady,
  output logic                   cmdReqIrq,
  output logic                   cmdRplIrq,
  output logic                   dnDoneIrq,
  output logic                   upDoneIrq
);
  dmaStrobe_t strobe;
  logic [REG_W-1:0] dnAddr, dnRem, upAddr, upRem;

  ac97_host_ctrl #(.ADDR_W(ADDR_W), .REG_W(REG_W)) ctrl_i (
    .clk(clk), .rstN(rstN),
    .regWrEn(regWrEn), .regAddr(regAddr), .regByteEn(regByteEn),
    .regWrData(regWrData), .regRdData(regRdData),
    .dnAddr(dnAddr), .dnRem(dnRem), .upAddr(upAddr), .upRem(upRem),
    .strobe(strobe), .cmdReqIrq(cmdReqIrq), .cmdRplIrq(cmdRplIrq)
  );

  ac97_host_datapath #(.REG_W(REG_W), .FRAME_W(FRAME_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(regWrData),
    .dnAddr(dnAddr), .dnRem(dnRem), .upAddr(upAddr), .upRem(upRem),
    .memRdEn(memRdEn), .memRdAddr(memRdAddr), .memRdData(memRdData),
    .memWrEn(memWrEn), .memWrAddr(memWrAddr), .memWrData(memWrData),
    .memWrStrb(memWrStrb),
    .pbValid(pbValid), .pbData(pbData), .pbKeep(pbKeep), .pbReady(pbReady),
    .capValid(capValid), .capData(capData), .capReady(capReady),
    .dnDoneIrq(dnDoneIrq), .upDoneIrq(upDoneIrq)
  );
endmodule

// File: tb/ac97_host_dma_tb_top.sv
module ac97_host_dma_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic [5:0] regAddr = '0;
  logic [3:0] regByteEn = 4'hF;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic memRdEn, memWrEn, pbValid, capReady;
  logic [31:0] memRdAddr, memWrAddr, memWrData, pbData;
  logic [31:0] memRdData = '0;
  logic [3:0] memWrStrb, pbKeep;
  logic pbReady = 1'b1;
  logic capValid = 1'b0;
  logic [31:0] capData = '0;
  logic cmdReqIrq, cmdRplIrq, dnDoneIrq, upDoneIrq;

  always #5 clk = ~clk;

  ac97_host_dma dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regByteEn(regByteEn), .regWrData(regWrData), .regRdData(regRdData),
    .memRdEn(memRdEn), .memRdAddr(memRdAddr), .memRdData(memRdData),
    .memWrEn(memWrEn), .memWrAddr(memWrAddr), .memWrData(memWrData),
    .memWrStrb(memWrStrb), .pbValid(pbValid), .pbData(pbData),
    .pbKeep(pbKeep), .pbReady(pbReady), .capValid(capValid),
    .capData(capData), .capReady(capReady), .cmdReqIrq(cmdReqIrq),
    .cmdRplIrq(cmdRplIrq), .dnDoneIrq(dnDoneIrq), .upDoneIrq(upDoneIrq)
  );

  function automatic logic [31:0] memFun(input logic [31:0] a);
    return {~a[15:0], a[15:0]};
  endfunction

  // Memory model: one-cycle read latency
  always @(posedge clk) memRdData <= memFun(memRdAddr);

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  // Monitor logs
  int rdCnt = 0, pbCnt = 0, wrCnt = 0, dnIrqCnt = 0, upIrqCnt = 0, reqCnt = 0, rplCnt = 0;
  logic [31:0] rdLog [8];
  logic [31:0] pbLog [8];
  logic [3:0]  keepLog [8];
  logic [31:0] wrAddrLog [8];
  logic [31:0] wrDataLog [8];
  logic [3:0]  wrStrbLog [8];

  always begin
    @(negedge clk);
    #1;
    if (rstN) begin
      if (memRdEn) begin if (rdCnt < 8) rdLog[rdCnt] = memRdAddr; rdCnt++; end
      if (pbValid && pbReady) begin
        if (pbCnt < 8) begin pbLog[pbCnt] = pbData; keepLog[pbCnt] = pbKeep; end
        pbCnt++;
      end
      if (memWrEn) begin
        if (wrCnt < 8) begin
          wrAddrLog[wrCnt] = memWrAddr; wrDataLog[wrCnt] = memWrData; wrStrbLog[wrCnt] = memWrStrb;
        end
        wrCnt++;
      end
      if (dnDoneIrq) dnIrqCnt++;
      if (upDoneIrq) upIrqCnt++;
      if (cmdReqIrq) reqCnt++;
      if (cmdRplIrq) rplCnt++;
    end
  end

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic clearLog();
    @(negedge clk);
    rdCnt = 0; pbCnt = 0; wrCnt = 0; dnIrqCnt = 0; upIrqCnt = 0; reqCnt = 0; rplCnt = 0;
  endtask

  task automatic waitCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic writeReg(input int idx, input logic [31:0] val, input logic [3:0] be = 4'hF);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = 6'(idx * 4); regWrData = val; regByteEn = be;
    @(negedge clk);
    regWrEn = 1'b0; regByteEn = 4'hF;
  endtask

  task automatic readReg(input int idx, output logic [31:0] val, input logic [3:0] be = 4'hF);
    @(negedge clk);
    regAddr = 6'(idx * 4); regByteEn = be;
    #1;
    val = regRdData;
    regByteEn = 4'hF;
  endtask

  task automatic testReset();
    logic [31:0] v;
    for (int i = 0; i < 11; i++) begin
      readReg(i, v);
      check("R10", $sformatf("reg %0d after reset", i), v, 32'h0);
    end
    check("R10", "outputs idle", {28'h0, memRdEn, memWrEn, pbValid, capReady}, 32'h0);
    check("R10", "irqs idle", {28'h0, cmdReqIrq, cmdRplIrq, dnDoneIrq, upDoneIrq}, 32'h0);
  endtask

  task automatic testReadback();
    logic [31:0] v;
    writeReg(1, 32'h1111_0001);
    writeReg(2, 32'h2222_0002);
    writeReg(3, 32'h3333_0003);
    writeReg(5, 32'h0000_5550);
    writeReg(9, 32'h0000_9990);
    writeReg(6, 32'h0000_0040);
    writeReg(10, 32'h0000_0080);
    readReg(1, v);  check("R1", "cmd addr", v, 32'h1111_0001);
    readReg(2, v);  check("R1", "cmd dout", v, 32'h2222_0002);
    readReg(3, v);  check("R1", "cmd din", v, 32'h3333_0003);
    readReg(5, v);  check("R1", "dn addr", v, 32'h0000_5550);
    readReg(9, v);  check("R1", "up addr", v, 32'h0000_9990);
    readReg(6, v);  check("R1", "dn rem", v, 32'h0000_0040);
    readReg(10, v); check("R1", "up rem", v, 32'h0000_0080);
  endtask

  task automatic testCommand();
    logic [31:0] v;
    clearLog();
    writeReg(0, 32'h0000_0F03);
    check("R3", "req pulse on write cmd", {30'h0, cmdReqIrq, cmdRplIrq}, 32'h2);
    waitCycles(2);
    check("R3", "req pulse count", reqCnt, 1);
    readReg(0, v); check("R2", "request bit self-clears", v, 32'h0000_0F02);
    clearLog();
    writeReg(0, 32'h0000_0001);
    check("R3", "reply pulse on read cmd", {30'h0, cmdReqIrq, cmdRplIrq}, 32'h1);
    waitCycles(2);
    check("R3", "reply pulse count", rplCnt, 1);
    readReg(0, v); check("R2", "readback after reply", v, 32'h0);
    clearLog();
    writeReg(0, 32'h0000_0002);
    waitCycles(2);
    check("R3", "no pulse without request bit", reqCnt + rplCnt, 0);
    readReg(0, v); check("R2", "direction bit stored", v, 32'h2);
  endtask

  task automatic testAccessRules();
    logic [31:0] v;
    clearLog();
    writeReg(1, 32'hDEAD_BEEF, 4'h3);
    readReg(1, v); check("R8", "partial write ignored", v, 32'h1111_0001);
    readReg(1, v, 4'h1); check("R8", "partial read returns 0", v, 32'h0);
    writeReg(0, 32'h3, 4'h7);
    waitCycles(2);
    check("R8", "partial cmd write no pulse", reqCnt + rplCnt, 0);
    writeReg(7, 32'hFFFF_FFFF);
    readReg(7, v); check("R9", "reserved slot reads 0", v, 32'h0);
    writeReg(12, 32'hFFFF_FFFF);
    readReg(12, v); check("R9", "unknown slot reads 0", v, 32'h0);
    readReg(2, v); check("R9", "neighbour untouched", v, 32'h2222_0002);
  endtask

  task automatic testDisabled();
    logic [31:0] v;
    clearLog();
    writeReg(5, 32'h400); writeReg(6, 32'h8);
    writeReg(9, 32'h500); writeReg(10, 32'h8);
    capValid = 1'b1; capData = 32'h1234_5678;
    waitCycles(10);
    check("R4", "disabled playback no reads", rdCnt, 0);
    check("R4", "disabled capture no writes", wrCnt, 0);
    check("R4", "disabled capReady low", {31'h0, capReady}, 32'h0);
    readReg(6, v); check("R4", "dn rem unchanged", v, 32'h8);
    readReg(10, v); check("R4", "up rem unchanged", v, 32'h8);
    capValid = 1'b0;
  endtask

  task automatic testPlayback();
    logic [31:0] v;
    pbReady = 1'b1;
    writeReg(5, 32'h100); writeReg(6, 32'd10);
    clearLog();
    writeReg(4, 32'h1);
    waitCycles(20);
    check("R5", "playback beats", rdCnt, 3);
    check("R5", "read addr 0", rdLog[0], 32'h100);
    check("R5", "read addr 1", rdLog[1], 32'h104);
    check("R5", "read addr 2", rdLog[2], 32'h108);
    check("R5", "frames delivered", pbCnt, 3);
    for (int k = 0; k < 3; k++)
      check("R5", $sformatf("frame %0d data", k), pbLog[k], memFun(32'h100 + 32'(4 * k)));
    check("R5", "full keep", {28'h0, keepLog[0]}, 32'hF);
    check("R5", "last keep", {28'h0, keepLog[2]}, 32'h3);
    check("R6", "one playback done pulse", dnIrqCnt, 1);
    readReg(5, v); check("R5", "dn addr advanced", v, 32'h10A);
    readReg(6, v); check("R5", "dn rem zero", v, 32'h0);
    waitCycles(8);
    check("R7", "no beat at zero count", rdCnt, 3);
    writeReg(4, 32'h0);
  endtask

  task automatic testPlaybackStall();
    logic [31:0] v;
    pbReady = 1'b0;
    writeReg(5, 32'h300); writeReg(6, 32'd8);
    clearLog();
    writeReg(4, 32'h1);
    waitCycles(10);
    check("R7", "stall fetches one frame", rdCnt, 1);
    check("R7", "stalled frame held", {31'h0, pbValid}, 32'h1);
    check("R7", "stalled frame data", pbData, memFun(32'h300));
    check("R7", "no done during stall", dnIrqCnt, 0);
    readReg(6, v); check("R7", "rem after one beat", v, 32'h4);
    @(negedge clk); pbReady = 1'b1;
    waitCycles(10);
    check("R6", "stall resumed beats", rdCnt, 2);
    check("R6", "done after resume", dnIrqCnt, 1);
    writeReg(4, 32'h0);
  endtask

  task automatic testCapture();
    logic [31:0] v;
    writeReg(9, 32'h200); writeReg(10, 32'd6);
    capData = 32'hCAFE_0001; capValid = 1'b1;
    clearLog();
    writeReg(8, 32'h1);
    waitCycles(10);
    check("R5", "capture writes", wrCnt, 2);
    check("R5", "write addr 0", wrAddrLog[0], 32'h200);
    check("R5", "write addr 1", wrAddrLog[1], 32'h204);
    check("R5", "write data", wrDataLog[1], 32'hCAFE_0001);
    check("R5", "full strobe", {28'h0, wrStrbLog[0]}, 32'hF);
    check("R5", "partial strobe", {28'h0, wrStrbLog[1]}, 32'h3);
    check("R6", "one capture done pulse", upIrqCnt, 1);
    check("R7", "capReady low at zero", {31'h0, capReady}, 32'h0);
    readReg(9, v); check("R5", "up addr advanced", v, 32'h206);
    capValid = 1'b0;
    writeReg(10, 32'd8);
    clearLog();
    waitCycles(10);
    check("R7", "no capture without valid", wrCnt, 0);
    readReg(10, v); check("R7", "up rem held", v, 32'h8);
    check("R7", "no capture done", upIrqCnt, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testReadback();
    testCommand();
    testAccessRules();
    testDisabled();
    testPlayback();
    testPlaybackStall();
    testCapture();
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule